// File: doc/BRIEF.md
# Hash Core Register Shell

This block is the register front end of a hash accelerator. A host on a simple 32-bit register bus reads identification words, writes the message block one word at a time, starts the engine with a command word, polls a status word and reads back the digest. The compression engine itself sits outside the shell. The shell drives one-cycle start pulses (first block and following block), a variant-mode code and the assembled block toward the engine. It receives the engine's ready flag, its digest-valid flag and the digest words.

The narrow build (`WIDE = 0`) serves 512-bit-block engines and places the digest window at 0x20. The wide build (`WIDE = 1`) serves the 1024-bit-block engine, places the digest window at 0x40 and adds a two-bit variant selector to the command word. The bus read path is combinational. Writes take effect on the clock edge that samples them.

Top module: `hsh_regshell`

## Requirements
- R1: Addresses 0x00, 0x01 and 0x02 read as the constant parameters ID_HI, ID_LO and REV. A write to any of them leaves the value read back unchanged.
- R2: A write to the command word (0x08) that is accepted raises `eng_init` for exactly one cycle, starting the cycle after the write, when bit 0 is 1. It raises `eng_next` the same way when bit 1 is 1 and bit 0 is 0. When both bits are 1, only `eng_init` fires.
- R3: Reading 0x08 returns zero in bits 0 and 1 and in bits 31:4. Bits 3:2 hold the stored mode.
- R4: A command write made while `eng_ready` is low is dropped. It produces no pulse and leaves the mode unchanged.
- R5: Reading 0x09 returns `eng_ready` in bit 0 and the shell's digest-valid flag in bit 1. All other bits read as zero.
- R6: The digest-valid flag reads 0 from the cycle a start pulse is issued until the engine next raises `eng_valid` from low to high. While `eng_valid` is high and no start is pending, the flag reads 1.
- R7: A write to 0x10+i (i below BLOCK_WORDS) stores word i. Word 0, the earliest message bytes, drives the most significant 32 bits of `eng_block`. The block window reads as zero.
- R8: A read of DIG_BASE+i returns digest word i, where word 0 is the most significant 32 bits of `eng_digest`. DIG_BASE is 0x20 when WIDE=0 and 0x40 when WIDE=1.
- R9: When WIDE=1, bits 3:2 of an accepted command write drive `eng_mode` (0: 512/224, 1: 512/256, 2: 384, 3: 512). When WIDE=0, `eng_mode` stays 0.
- R10: A read of an unmapped address returns zero. A write to an unmapped address, to the status word or to the digest window changes neither `eng_block`, the mode nor any read-back value.
- R11: After reset, `eng_block` is zero, the mode is 0, no start pulse is active and the digest-valid flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| eng_init | output | 1 | One-cycle first-block start pulse |
| eng_next | output | 1 | One-cycle following-block start pulse |
| eng_mode | output | 2 | Variant selector |
| eng_block | output | BLOCK_WORDS*32 | Assembled message block, word 0 at the top |
| eng_ready | input | 1 | Engine idle and able to start |
| eng_valid | input | 1 | Engine digest valid |
| eng_digest | input | DIGEST_WORDS*32 | Digest, word 0 at the top |

## Verification
Assertions check several rules on every cycle:
- the two start pulses never coincide;
- a start is issued only after a cycle in which the engine reported ready;
- the valid flag is masked in any cycle that carries a start;
- the mode and the block storage hold when no write targets them;
- unmapped reads return zero.

Other behaviours need the bench's scenarios. These are the exact pulse timing and width, the dropping of a command while the engine is busy, the stale valid flag being hidden before the engine has even seen the start, the ordering of words in the block and digest windows, and the placement of the digest window in the narrow build compared with the wide build.

// File: rtl/hsh_pkg.sv
package hsh_pkg;
  typedef logic [31:0] word_t;

  localparam logic [7:0] A_ID_HI = 8'h00;
  localparam logic [7:0] A_ID_LO = 8'h01;
  localparam logic [7:0] A_REV   = 8'h02;
  localparam logic [7:0] A_CMD   = 8'h08;
  localparam logic [7:0] A_STAT  = 8'h09;
  localparam logic [7:0] A_BLK   = 8'h10;

  localparam int CMD_FIRST = 0;
  localparam int CMD_MORE  = 1;

  // address a lies in [base, base+cnt)
  function automatic logic in_window(input logic [7:0] a, input int base, input int cnt);
    return (int'(a) >= base) && (int'(a) < base + cnt);
  endfunction

  function automatic word_t cmd_view(input logic [1:0] m);
    return {28'b0, m, 2'b00};
  endfunction

  function automatic word_t stat_view(input logic rdy, input logic vld);
    return {30'b0, vld, rdy};
  endfunction
endpackage

// File: rtl/hsh_ctrl.sv
module hsh_ctrl #(
  parameter int WIDE = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [3:0] cmd_bits,
  input  logic       eng_ready,
  input  logic       eng_valid,
  output logic       eng_init,
  output logic       eng_next,
  output logic [1:0] mode_q,
  output logic       stat_valid
);
  import hsh_pkg::*;

  logic accept;      // command taken this cycle
  logic start_req;   // accepted command carries a start
  logic valid_rise;  // engine valid went low to high
  logic init_q, next_q, wait_q, vprev_q;

  assign accept     = cmd_wr & eng_ready;
  assign start_req  = accept & (cmd_bits[CMD_FIRST] | cmd_bits[CMD_MORE]);
  assign valid_rise = eng_valid & ~vprev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= 1'b0;
      next_q  <= 1'b0;
      wait_q  <= 1'b1;
      vprev_q <= 1'b0;
    end else begin
      init_q  <= accept & cmd_bits[CMD_FIRST];
      next_q  <= accept & cmd_bits[CMD_MORE] & ~cmd_bits[CMD_FIRST];
      vprev_q <= eng_valid;
      if (start_req)       wait_q <= 1'b1;
      else if (valid_rise) wait_q <= 1'b0;
    end
  end

  generate
    if (WIDE != 0) begin : g_mode
      logic [1:0] mode_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mode_r <= 2'd0;
        else if (accept) mode_r <= cmd_bits[3:2];
      end
      assign mode_q = mode_r;
    end else begin : g_nomode
      assign mode_q = 2'd0;
    end
  endgenerate

  assign eng_init   = init_q;
  assign eng_next   = next_q;
  assign stat_valid = eng_valid & ~wait_q;

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_init && eng_next)); // R2
  AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_init || eng_next) |-> $past(eng_ready)); // R4
  AST_VALID_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_init || eng_next) |-> !stat_valid); // R6
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(mode_q)); // R9
endmodule

// File: rtl/hsh_blkbuf.sv
module hsh_blkbuf #(
  parameter int WORDS = 16,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   widx,
  input  logic [31:0]        wdata,
  output logic [WORDS*32-1:0] blk
);
  logic [31:0] word_q [WORDS];

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              word_q[g] <= 32'd0;
        else if (wr_en && (int'(widx) == g))     word_q[g] <= wdata;
      end
      assign blk[(WORDS-1-g)*32 +: 32] = word_q[g];
    end
  endgenerate

  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(blk)); // R10
endmodule

// File: rtl/hsh_rdmux.sv
module hsh_rdmux #(
  parameter logic [31:0] ID_HI = 32'h0,
  parameter logic [31:0] ID_LO = 32'h0,
  parameter logic [31:0] REV   = 32'h0,
  parameter int DIGEST_WORDS   = 8,
  parameter int DIG_BASE       = 32,
  localparam int DIDX_W = (DIGEST_WORDS > 1) ? $clog2(DIGEST_WORDS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [7:0]                addr,
  input  logic [1:0]                mode,
  input  logic                      ready,
  input  logic                      valid,
  input  logic [DIGEST_WORDS*32-1:0] digest,
  output logic [31:0]               rdata
);
  import hsh_pkg::*;

  logic [31:0] dig_w [DIGEST_WORDS];
  logic [7:0]  doff;
  logic        dig_hit, reg_hit;

  generate
    for (genvar g = 0; g < DIGEST_WORDS; g++) begin : g_dig
      assign dig_w[g] = digest[(DIGEST_WORDS-1-g)*32 +: 32];
    end
  endgenerate

  assign doff    = addr - 8'(DIG_BASE);
  assign dig_hit = in_window(addr, DIG_BASE, DIGEST_WORDS);
  assign reg_hit = (addr == A_ID_HI) || (addr == A_ID_LO) || (addr == A_REV) ||
                   (addr == A_CMD) || (addr == A_STAT) || dig_hit;

  always_comb begin
    rdata = 32'd0;
    if (rd_en) begin
      if (addr == A_ID_HI)     rdata = ID_HI;
      else if (addr == A_ID_LO) rdata = ID_LO;
      else if (addr == A_REV)   rdata = REV;
      else if (addr == A_CMD)   rdata = cmd_view(mode);
      else if (addr == A_STAT)  rdata = stat_view(ready, valid);
      else if (dig_hit)         rdata = dig_w[doff[DIDX_W-1:0]];
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !reg_hit) |-> (rdata == 32'd0)); // R10
endmodule

// File: rtl/hsh_regshell.sv
module hsh_regshell #(
  parameter int WIDE         = 0,
  parameter int BLOCK_WORDS  = 16,
  parameter int DIGEST_WORDS = 8,
  parameter logic [31:0] ID_HI = 32'h68617368,
  parameter logic [31:0] ID_LO = 32'h636f7265,
  parameter logic [31:0] REV   = 32'h00010000,
  localparam int DIG_BASE = (WIDE != 0) ? 64 : 32,
  localparam int BIDX_W   = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_cs,
  input  logic                       bus_we,
  input  logic [7:0]                 bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic                       eng_init,
  output logic                       eng_next,
  output logic [1:0]                 eng_mode,
  output logic [BLOCK_WORDS*32-1:0]  eng_block,
  input  logic                       eng_ready,
  input  logic                       eng_valid,
  input  logic [DIGEST_WORDS*32-1:0] eng_digest
);
  import hsh_pkg::*;

  logic       wr_any, rd_any, cmd_wr, blk_wr, stat_valid;
  logic [7:0] boff;
  logic [1:0] mode_q;

  assign wr_any = bus_cs & bus_we;
  assign rd_any = bus_cs & ~bus_we;
  assign cmd_wr = wr_any & (bus_addr == A_CMD);
  assign blk_wr = wr_any & in_window(bus_addr, int'(A_BLK), BLOCK_WORDS);
  assign boff   = bus_addr - A_BLK;

  hsh_ctrl #(.WIDE(WIDE)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_bits(bus_wdata[3:0]),
    .eng_ready(eng_ready), .eng_valid(eng_valid),
    .eng_init(eng_init), .eng_next(eng_next),
    .mode_q(mode_q), .stat_valid(stat_valid)
  );

  hsh_blkbuf #(.WORDS(BLOCK_WORDS)) u_blk (
    .clk(clk), .rst_n(rst_n),
    .wr_en(blk_wr), .widx(boff[BIDX_W-1:0]), .wdata(bus_wdata),
    .blk(eng_block)
  );

  hsh_rdmux #(
    .ID_HI(ID_HI), .ID_LO(ID_LO), .REV(REV),
    .DIGEST_WORDS(DIGEST_WORDS), .DIG_BASE(DIG_BASE)
  ) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_any), .addr(bus_addr), .mode(mode_q),
    .ready(eng_ready), .valid(stat_valid), .digest(eng_digest),
    .rdata(bus_rdata)
  );

  assign eng_mode = mode_q;
endmodule

// File: tb/tb_hsh_regshell.sv
module tb_hsh_regshell;
  localparam int BW = 32;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          bus_cs = 1'b0, bus_we = 1'b0;
  logic [7:0]    bus_addr = 8'h0;
  logic [31:0]   bus_wdata = 32'h0;
  logic [31:0]   bus_rdata, rdata_n;
  logic          eng_init, eng_next, init_n, next_n;
  logic [1:0]    eng_mode, mode_n;
  logic [BW*32-1:0] eng_block;
  logic [16*32-1:0] blk_n;
  logic          stub_rdy, stub_vld;
  logic [DW*32-1:0] stub_dig;
  int            stub_cnt;

  hsh_regshell #(.WIDE(1), .BLOCK_WORDS(BW), .DIGEST_WORDS(DW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_init(eng_init), .eng_next(eng_next), .eng_mode(eng_mode),
    .eng_block(eng_block), .eng_ready(stub_rdy), .eng_valid(stub_vld),
    .eng_digest(stub_dig)
  );

  hsh_regshell #(.WIDE(0), .BLOCK_WORDS(16), .DIGEST_WORDS(8)) dut_n (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_n),
    .eng_init(init_n), .eng_next(next_n), .eng_mode(mode_n),
    .eng_block(blk_n), .eng_ready(stub_rdy), .eng_valid(stub_vld),
    .eng_digest(stub_dig[DW*32-1 -: 256])
  );

  function automatic logic [31:0] dig_word(input int i);
    return 32'hD000_0000 | (32'(i) << 8) | 32'(i);
  endfunction

  initial begin
    for (int i = 0; i < DW; i++) stub_dig[(DW-1-i)*32 +: 32] = dig_word(i);
  end

  // behavioural engine: busy for a few cycles after each start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stub_rdy <= 1'b1; stub_vld <= 1'b0; stub_cnt <= 0;
    end else if (eng_init || eng_next) begin
      stub_rdy <= 1'b0; stub_vld <= 1'b0; stub_cnt <= 5;
    end else if (stub_cnt != 0) begin
      stub_cnt <= stub_cnt - 1;
      if (stub_cnt == 1) begin stub_rdy <= 1'b1; stub_vld <= 1'b1; end
    end
  end

  int checks = 0, errors = 0;
  int init_cnt = 0, next_cnt = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        sb_rd = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // pulse-width counters, sampled mid-cycle
  always @(negedge clk) begin
    if (eng_init) init_cnt++;
    if (eng_next) next_cnt++;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (sb_rd && bus_cs && !bus_we) begin
      if (exp_q.size() == 0) check("SB empty queue", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; sb_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a; sb_rd = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_now(input logic [7:0] a, output logic [31:0] v, output logic [31:0] vn);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a; sb_rd = 1'b0;
    #1; v = bus_rdata; vn = rdata_n;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    bus_cs = 1'b0; bus_we = 1'b0; sb_rd = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_valid(input string tag);
    logic [31:0] v, vn;
    v = 0;
    for (int k = 0; k < 40 && v != 32'd3; k++) rd_now(8'h09, v, vn);
    check(tag, v, 32'd3);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, vn;
    logic [BW*32-1:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 block zero", {31'b0, |eng_block}, 32'd0);
    check("R11 no pulses", {30'b0, eng_init, eng_next}, 32'd0);
    check("R11 mode zero", {30'b0, eng_mode}, 32'd0);
    rd_exp(8'h09, 32'd1, "R11 R5 status after reset");

    // R1 identification words, write ignored
    rd_exp(8'h00, 32'h68617368, "R1 id hi");
    rd_exp(8'h01, 32'h636f7265, "R1 id lo");
    rd_exp(8'h02, 32'h00010000, "R1 rev");
    wr(8'h00, 32'h1234_5678);
    wr(8'h02, 32'hFFFF_FFFF);
    rd_exp(8'h00, 32'h68617368, "R1 id hi after write");
    rd_exp(8'h02, 32'h00010000, "R1 rev after write");

    // R7 block window
    for (int i = 0; i < BW; i++) wr(8'h10 + 8'(i), 32'hB000_0000 + 32'(i));
    idle(1);
    check("R7 word0 at top", eng_block[BW*32-1 -: 32], 32'hB000_0000);
    check("R7 last word at bottom", eng_block[31:0], 32'hB000_001F);
    check("R7 word5", eng_block[(BW-1-5)*32 +: 32], 32'hB000_0005);
    rd_exp(8'h11, 32'd0, "R7 block window reads zero");

    // R2 R9 init with mode 384
    wr(8'h08, 32'h0000_0009);
    check("R2 init pulse", {30'b0, eng_init, eng_next}, 32'd2);
    check("R9 mode 384", {30'b0, eng_mode}, 32'd2);
    rd_exp(8'h08, 32'h0000_0008, "R3 command readback");
    idle(1);
    check("R2 init one cycle", 32'(init_cnt), 32'd1);

    // R4 write while busy ignored
    wr(8'h08, 32'h0000_0006);
    rd_exp(8'h09, 32'd0, "R5 status busy");
    rd_exp(8'h08, 32'h0000_0008, "R4 mode unchanged while busy");
    idle(1);
    check("R4 no next while busy", 32'(next_cnt), 32'd0);
    check("R4 mode port unchanged", {30'b0, eng_mode}, 32'd2);

    wait_valid("R6 R5 valid after first block");

    // R8 digest window, wide and narrow
    for (int i = 0; i < DW; i++) rd_exp(8'h40 + 8'(i), dig_word(i), "R8 wide digest word");
    rd_now(8'h20, v, vn);
    check("R8 narrow base word0", vn, dig_word(0));
    check("R7 wide 0x20 is block window", v, 32'd0);
    rd_now(8'h27, v, vn);
    check("R8 narrow word7", vn, dig_word(7));

    // R6 stale valid hidden before engine sees the start
    wr(8'h08, 32'h0000_000E);
    rd_exp(8'h09, 32'd1, "R6 valid masked right after start");
    check("R2 next pulse", {30'b0, eng_init, eng_next}, 32'd0);
    idle(1);
    check("R2 next one cycle", 32'(next_cnt), 32'd1);
    check("R9 mode 512", {30'b0, eng_mode}, 32'd3);
    check("R9 narrow mode stays 0", {30'b0, mode_n}, 32'd0);
    wait_valid("R6 valid returns");

    // R2 both bits -> init only
    wr(8'h08, 32'h0000_0003);
    check("R2 both bits init", {30'b0, eng_init, eng_next}, 32'd2);
    idle(1);
    check("R2 init count", 32'(init_cnt), 32'd2);
    check("R2 next count", 32'(next_cnt), 32'd1);
    wait_valid("R6 valid third");

    // R10 unmapped access
    snap = eng_block;
    wr(8'h05, 32'hDEAD_BEEF);
    wr(8'h60, 32'hDEAD_BEEF);
    wr(8'h09, 32'hFFFF_FFFF);
    wr(8'h41, 32'hFFFF_FFFF);
    idle(1);
    check("R10 block unchanged", {31'b0, (eng_block !== snap)}, 32'd0);
    check("R10 mode unchanged", {30'b0, eng_mode}, 32'd0);
    rd_exp(8'h05, 32'd0, "R10 unmapped 0x05");
    rd_exp(8'h60, 32'd0, "R10 unmapped 0x60");
    rd_exp(8'h0A, 32'd0, "R10 unmapped 0x0A");
    rd_exp(8'h09, 32'd3, "R10 status unchanged");
    rd_exp(8'h41, dig_word(1), "R10 digest unchanged");
    idle(2);

    check("SB queue drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule